// File: doc/BRIEF.md
# Complement-Address Disturb Tester

This block runs one of two disturb tests over a single memory bank through a plain synchronous memory port. Either test starts by writing a background word into every location. The scan test then visits each address in ascending order. At each one it confirms the background value, writes the inverse, confirms the inverse and puts the background back. The flap test walks the bank in the same way. Each time it reads or flips the target word, it also reads the word whose address is the bitwise inverse of the target. A fault in the address decoder that couples the two words shows up at once.

After the walk, a closing sweep reads every word against the background value. The first mismatch stops the test. The block then reports the address that was actually read, the value it expected and the value it got. A test is launched with a one-cycle start pulse, which also selects the test and supplies the background word. Completion or failure is signalled by a one-cycle done pulse.

Top module: `cad_tester`

## Requirements
- R1: After reset, done, err and mem_req are all 0.
- R2: A start pulse while idle latches bg and mode (mode 0 selects scan, mode 1 selects flap). The block then writes bg to every address from 0 to 2^AW-1 in ascending order.
- R3: In scan mode, the walk visits each address a in ascending order with four accesses: read a expecting bg, write ~bg to a, read a expecting ~bg, write bg to a.
- R4: In flap mode, the walk visits each address a in ascending order with seven accesses. The partner address p is ~a. The accesses are: read a (bg), read p (bg), write ~bg to a, read p (bg), read a (~bg), read p (bg), write bg to a.
- R5: After the walk, every address is read in ascending order expecting bg. If all reads match, done is high for exactly one cycle with err 0.
- R6: Every access is a one-cycle mem_req, and requests are RD_LAT+2 cycles apart. Read data is taken RD_LAT cycles after the request cycle. A clean run of N accesses raises done 5*N cycles after the cycle that follows the start cycle, for the bench value RD_LAT=3.
- R7: On the first mismatch, no further request is issued and done pulses with err 1. err_addr is the address actually read, which is the partner address for a partner check. err_exp is the expected value, which is ~bg for a complement check. err_got is the data read.
- R8: err and its fields hold until the next accepted start, which clears err.
- R9: A start pulse while a test runs is ignored. The access sequence and its timing continue unchanged.
- R10: The first partner read of a flap walk goes to the all-ones address. The partner address falls by one each time the target rises by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle launch pulse, honoured only while idle |
| mode | input | 1 | Test select: 0 scan, 1 flap |
| bg | input | 16 | Background word, latched on start |
| mem_req | output | 1 | One-cycle access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid RD_LAT cycles after the request cycle |
| done | output | 1 | One-cycle end-of-test pulse |
| err | output | 1 | A mismatch stopped the last test |
| err_addr | output | AW | Address of the failing read |
| err_exp | output | 16 | Value the failing read expected |
| err_got | output | 16 | Value the failing read returned |

## Verification
The hardest case to reach from the ports is a failed partner check. It happens only when writing one word disturbs the word at the inverted address, and a correct memory never does that. The bench memory model therefore has a coupling fault: a write to address 5 flips bit 0 of address 58. The flap test must then stop on the first partner read after the target flip and report address 58. A second fault model forces one bit low at address 10 on reads. Together with a background whose bit is 0 there, it fails only the complement read in scan mode, which exercises the reporting of the inverted expected value.

// File: rtl/cad_pkg.sv
package cad_pkg;

  typedef enum logic [1:0] {PH_FILL, PH_WALK, PH_SWEEP} phase_t;

  // One access of the per-address walk
  typedef struct packed {
    logic we;       // write when 1
    logic partner;  // use the inverted address
    logic inv;      // data is the inverse of the background
  } step_t;

  localparam int STEP_W = 3;

  function automatic step_t walk_step(input logic flap, input logic [STEP_W-1:0] idx);
    step_t s;
    s = '{we: 1'b0, partner: 1'b0, inv: 1'b0};
    if (!flap) begin
      case (idx)
        3'd1:    s = '{we: 1'b1, partner: 1'b0, inv: 1'b1};
        3'd2:    s = '{we: 1'b0, partner: 1'b0, inv: 1'b1};
        3'd3:    s = '{we: 1'b1, partner: 1'b0, inv: 1'b0};
        default: s = '{we: 1'b0, partner: 1'b0, inv: 1'b0};
      endcase
    end else begin
      case (idx)
        3'd1, 3'd3, 3'd5: s = '{we: 1'b0, partner: 1'b1, inv: 1'b0};
        3'd2:    s = '{we: 1'b1, partner: 1'b0, inv: 1'b1};
        3'd4:    s = '{we: 1'b0, partner: 1'b0, inv: 1'b1};
        3'd6:    s = '{we: 1'b1, partner: 1'b0, inv: 1'b0};
        default: s = '{we: 1'b0, partner: 1'b0, inv: 1'b0};
      endcase
    end
    return s;
  endfunction

  function automatic logic [STEP_W-1:0] last_step(input logic flap);
    return flap ? 3'd6 : 3'd3;
  endfunction

endpackage

// File: rtl/cad_walker.sv
module cad_walker
  import cad_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          adv,
  input  logic          flap,
  input  logic [DW-1:0] bg,
  output logic          op_we,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          op_final
);

  localparam logic [AW-1:0] TOP_ADDR = '1;

  phase_t            phase;
  logic [STEP_W-1:0] step;
  logic [AW-1:0]     tgt;
  logic [AW-1:0]     ptr;
  step_t             st;

  always_comb begin
    st       = walk_step(flap, step);
    op_final = (phase == PH_SWEEP) && (tgt == TOP_ADDR);
    case (phase)
      PH_WALK: begin
        op_we   = st.we;
        op_addr = st.partner ? ptr : tgt;
        op_data = st.inv ? ~bg : bg;
      end
      PH_SWEEP: begin
        op_we   = 1'b0;
        op_addr = tgt;
        op_data = bg;
      end
      default: begin
        op_we   = 1'b1;
        op_addr = tgt;
        op_data = bg;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || init) begin
      phase <= PH_FILL;
      step  <= '0;
      tgt   <= '0;
      ptr   <= '1;
    end else if (adv) begin
      case (phase)
        PH_FILL: begin
          tgt <= tgt + 1'b1;
          if (tgt == TOP_ADDR) phase <= PH_WALK;
        end
        PH_WALK: begin
          if (step == last_step(flap)) begin
            step <= '0;
            tgt  <= tgt + 1'b1;
            ptr  <= ptr - 1'b1;
            if (tgt == TOP_ADDR) phase <= PH_SWEEP;
          end else begin
            step <= step + 1'b1;
          end
        end
        default: tgt <= tgt + 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/cad_check.sv
module cad_check #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          strobe,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] exp_d,
  input  logic [DW-1:0] got_d,
  output logic          miss,
  output logic          err,
  output logic [AW-1:0] err_addr,
  output logic [DW-1:0] err_exp,
  output logic [DW-1:0] err_got
);

  assign miss = strobe && (got_d != exp_d);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      err      <= 1'b0;
      err_addr <= '0;
      err_exp  <= '0;
      err_got  <= '0;
    end else if (miss) begin
      err      <= 1'b1;
      err_addr <= addr;
      err_exp  <= exp_d;
      err_got  <= got_d;
    end
  end

endmodule

// File: rtl/cad_tester.sv
module cad_tester #(
  parameter int AW     = 6,
  parameter int DW     = 16,
  parameter int RD_LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mode,
  input  logic [DW-1:0] bg,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] err_addr,
  output logic [DW-1:0] err_exp,
  output logic [DW-1:0] err_got
);

  localparam int CW = $clog2(RD_LAT + 1);
  localparam logic [CW-1:0] LAT = CW'(RD_LAT);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ISSUE, S_WAIT} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] bg_q;
  logic          flap_q;
  logic          launch;
  logic          at_sample;
  logic          adv;
  logic          miss;
  logic          op_we;
  logic          op_final;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;

  assign launch    = (state == S_IDLE) && start;
  assign at_sample = (state == S_WAIT) && (cnt == LAT);
  assign adv       = at_sample && !miss;

  cad_walker #(.AW(AW), .DW(DW)) u_walker (
    .clk      (clk),
    .rst      (rst),
    .init     (launch),
    .adv      (adv),
    .flap     (flap_q),
    .bg       (bg_q),
    .op_we    (op_we),
    .op_addr  (op_addr),
    .op_data  (op_data),
    .op_final (op_final)
  );

  cad_check #(.AW(AW), .DW(DW)) u_check (
    .clk      (clk),
    .rst      (rst),
    .clr      (launch),
    .strobe   (at_sample && !op_we),
    .addr     (op_addr),
    .exp_d    (op_data),
    .got_d    (mem_rdata),
    .miss     (miss),
    .err      (err),
    .err_addr (err_addr),
    .err_exp  (err_exp),
    .err_got  (err_got)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      bg_q      <= '0;
      flap_q    <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            bg_q   <= bg;
            flap_q <= mode;
            state  <= S_SETUP;
          end
        end
        S_SETUP: begin
          mem_req   <= 1'b1;
          mem_we    <= op_we;
          mem_addr  <= op_addr;
          mem_wdata <= op_data;
          state     <= S_ISSUE;
        end
        S_ISSUE: begin
          mem_req <= 1'b0;
          cnt     <= CW'(1);
          state   <= S_WAIT;
        end
        default: begin
          if (cnt == LAT) begin
            if (miss || op_final) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              state <= S_SETUP;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/cad_tester_chk.sv
module cad_tester_chk #(
  parameter int AW     = 6,
  parameter int RD_LAT = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          mem_req,
  input logic          done,
  input logic          err,
  input logic [AW-1:0] err_addr
);

  localparam int GW = $clog2(RD_LAT + 3);
  localparam logic [GW-1:0] GAP_MIN = GW'(RD_LAT + 1);

  logic [GW-1:0] gap;
  logic          idle_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap    <= GAP_MIN;
      idle_q <= 1'b1;
    end else begin
      if (mem_req) gap <= '0;
      else if (gap != GAP_MIN) gap <= gap + 1'b1;
      if (start) idle_q <= 1'b0;
      else if (done) idle_q <= 1'b1;
    end
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R6
  AST_REQ_SPACING: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (gap == GAP_MIN)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (idle_q && !start) |-> !mem_req); // R7
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> done); // R7
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (err && !start) |=> (err && $stable(err_addr))); // R8

endmodule

bind cad_tester cad_tester_chk #(.AW(AW), .RD_LAT(RD_LAT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .mem_req  (mem_req),
  .done     (done),
  .err      (err),
  .err_addr (err_addr)
);

// File: tb/cad_tester_bench.sv
`timescale 1ns/1ps
module cad_tester_bench;

  localparam int AW = 6;
  localparam int DW = 16;
  localparam int RD_LAT = 3;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          mode = 1'b0;
  logic [DW-1:0] bg = '0;
  logic          mem_req, mem_we, done, err;
  logic [AW-1:0] mem_addr, err_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, err_exp, err_got;

  always #2.5 clk = ~clk;

  cad_tester #(.AW(AW), .DW(DW), .RD_LAT(RD_LAT)) u_cad_tester (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .bg(bg),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
    .err(err), .err_addr(err_addr), .err_exp(err_exp), .err_got(err_got)
  );

  int n_chk = 0;
  int n_err = 0;
  int n_req = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Memory model with latency pipe and two injectable faults
  logic [DW-1:0] mem [NW];
  logic [DW-1:0] pipe [RD_LAT];
  bit            cpl_en = 0;
  logic [AW-1:0] cpl_src = '0, cpl_dst = '0;
  bit            stk_en = 0;
  logic [AW-1:0] stk_addr = '0;
  logic [DW-1:0] stk_mask = '0;

  assign mem_rdata = pipe[RD_LAT-1];

  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      mem[mem_addr] <= mem_wdata;
      if (cpl_en && mem_addr == cpl_src) mem[cpl_dst] <= mem[cpl_dst] ^ 16'h0001;
    end
    if (mem_req && !mem_we)
      pipe[0] <= (stk_en && mem_addr == stk_addr) ? (mem[mem_addr] & ~stk_mask)
                                                  : mem[mem_addr];
    for (int i = 1; i < RD_LAT; i++) pipe[i] <= pipe[i-1];
  end

  // Scoreboard
  typedef struct {
    bit            we;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    string         tag;
  } op_s;
  op_s exp_q[$];

  task automatic push(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input string tag);
    op_s o;
    o.we = we; o.a = a; o.d = d; o.tag = tag;
    exp_q.push_back(o);
  endtask

  task automatic push_run(input bit flap, input logic [DW-1:0] b);
    for (int i = 0; i < NW; i++) push(1'b1, AW'(i), b, "R2");
    for (int i = 0; i < NW; i++) begin
      logic [AW-1:0] a;
      logic [AW-1:0] p;
      a = AW'(i);
      p = ~a;
      if (!flap) begin
        push(1'b0, a, b, "R3");
        push(1'b1, a, ~b, "R3");
        push(1'b0, a, ~b, "R3");
        push(1'b1, a, b, "R3");
      end else begin
        push(1'b0, a, b, "R4");
        push(1'b0, p, b, (i == 0) ? "R10" : "R4");
        push(1'b1, a, ~b, "R4");
        push(1'b0, p, b, "R4");
        push(1'b0, a, ~b, "R4");
        push(1'b0, p, b, "R10");
        push(1'b1, a, b, "R4");
      end
    end
    for (int i = 0; i < NW; i++) push(1'b0, AW'(i), b, "R5");
  endtask

  // Monitor: compares every request against the queue
  always @(negedge clk) begin
    if (!rst && mem_req) begin
      n_req++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 request after end", {15'd0, mem_we, 10'd0, mem_addr}, 32'd0);
      end else begin
        op_s o;
        o = exp_q.pop_front();
        check((mem_we == o.we) && (mem_addr == o.a) && (!o.we || mem_wdata == o.d),
              o.tag, {mem_we, 9'd0, mem_addr, mem_wdata},
              {o.we, 9'd0, o.a, o.we ? o.d : mem_wdata});
      end
    end
  end

  // Runs one test; poke>0 pulses start (with other inputs) at that cycle
  task automatic run(input bit flap, input logic [DW-1:0] b, input int poke,
                     output int cycles, output logic err0);
    int k;
    exp_q.delete();
    push_run(flap, b);
    n_req = 0;
    mode  = flap;
    bg    = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    err0  = err;
    k = 0;
    while (!done && k < 20000) begin
      @(negedge clk);
      k++;
      if (poke > 0 && k == poke) begin
        start = 1'b1; bg = 16'h1234; mode = ~flap;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    cycles = k;
  endtask

  initial begin
    #(5.0 * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int   cyc;
    logic e0;
    repeat (4) @(negedge clk);
    check(done == 0 && err == 0 && mem_req == 0, "R1 reset state",
          {29'd0, done, err, mem_req}, 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // Clean scan run
    run(1'b0, 16'h3C5A, 0, cyc, e0);
    check(done == 1 && err == 0, "R5 scan clean done", {30'd0, done, err}, 32'd2);
    check(n_req == 384, "R2 R3 scan access count", n_req, 384);
    check(exp_q.size() == 0, "R3 scan sequence complete", exp_q.size(), 0);
    check(cyc == 5 * 384, "R6 scan timing", cyc, 5 * 384);
    @(negedge clk);
    check(done == 0, "R5 done is one cycle", done, 0);

    // Clean flap run
    run(1'b1, 16'h0000, 0, cyc, e0);
    check(done == 1 && err == 0, "R5 flap clean done", {30'd0, done, err}, 32'd2);
    check(n_req == 576, "R4 flap access count", n_req, 576);
    check(exp_q.size() == 0, "R4 R10 flap sequence complete", exp_q.size(), 0);
    check(cyc == 5 * 576, "R6 flap timing", cyc, 5 * 576);

    // Flap with a coupling fault: writing 5 flips bit 0 of 58
    cpl_en = 1; cpl_src = 6'd5; cpl_dst = 6'd58;
    run(1'b1, 16'hFFFF, 0, cyc, e0);
    check(err == 1, "R7 partner fault detected", err, 1);
    check(err_addr == 6'd58, "R7 partner address reported", err_addr, 58);
    check(err_exp == 16'hFFFF, "R7 partner expected", err_exp, 16'hFFFF);
    check(err_got == 16'hFFFE, "R7 partner read data", err_got, 16'hFFFE);
    check(n_req == 103, "R7 stop after fault", n_req, 103);
    check(cyc == 5 * 103, "R7 done timing on fault", cyc, 5 * 103);
    cpl_en = 0;
    repeat (20) @(negedge clk);
    check(err == 1 && err_addr == 6'd58, "R8 error held", {25'd0, err, err_addr},
          {25'd0, 1'b1, 6'd58});
    check(n_req == 103, "R7 no request while idle", n_req, 103);

    // New scan run clears err; mid-run start is ignored
    run(1'b0, 16'h9001, 700, cyc, e0);
    check(e0 == 0, "R8 start clears error", e0, 0);
    check(err == 0 && n_req == 384, "R9 start while running ignored",
          {err, 15'd0, 16'(n_req)}, 32'd384);
    check(cyc == 5 * 384, "R9 timing unchanged", cyc, 5 * 384);

    // Scan with bit 3 stuck low at address 10: only the complement read fails
    stk_en = 1; stk_addr = 6'd10; stk_mask = 16'h0008;
    run(1'b0, 16'hA5A0, 0, cyc, e0);
    check(err == 1 && err_addr == 6'd10, "R7 scan fault address",
          {25'd0, err, err_addr}, {25'd0, 1'b1, 6'd10});
    check(err_exp == 16'h5A5F, "R7 complement expected", err_exp, 16'h5A5F);
    check(err_got == 16'h5A57, "R7 complement read data", err_got, 16'h5A57);
    check(n_req == 107, "R7 scan stop point", n_req, 107);
    stk_en = 0;

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule